// File: doc/BRIEF.md
# Boundary-Scan Test Access Port with Identification Register

This block is the serial test port of a chip. It has a sixteen-state controller stepped by the test clock and the mode input. It also has a four-bit instruction register and three data registers that can sit between the serial input and the serial output: a one-bit pass-through stage, a fixed 32-bit identification word, and a boundary register whose length is a parameter. Board test equipment uses the port to read the identification word and to sample the chip's pins. It can also take over the pins' drivers and drive values of its own onto them.

When the port leaves reset, or whenever the controller passes through its reset state, the identification instruction is selected. Reading a data scan right after reset therefore returns the identification word. The top bit of the boundary register is an output-enable control. It is preset high, and while the external-test instruction is active it decides whether the pin drivers are on. Under any other instruction the drivers follow the core's own enable.

Top module: `tap_port`

## Requirements
- R1: When an instruction scan captures, the instruction shift register loads binary 01 in its two low bits and zero in all other bits. Bits leave least significant first, so the first four bits out of a 4-bit scan read back as 4'b0001.
- R2: Synchronous reset `rst`, and every TCK rising edge spent in Test-Logic-Reset, select the identification instruction (code 4'b0001).
- R3: Under the identification instruction, a data scan shifts out a 32-bit word, least significant bit first. Bit 0 is 1. Bits 11:1 are a manufacturer field (default 11'h0A4). Bits 17:12 are a part field (default 6'b010010). Bits 23:18 are an architecture field (default 6'b100110). Bits 28:24 are a depth field of 01011. Bits 31:29 are a revision field of 000.
- R4: The bypass instruction (4'b1111) puts a single stage between TDI and TDO. This stage captures 0, so data comes out one shift later than it went in.
- R5: Any instruction code other than 4'b0000, 4'b0001, 4'b0010 and 4'b1111 acts as bypass.
- R6: The sample instruction (4'b0010) loads `bnd_capture` when the data scan captures and shifts it out least significant bit first. When the data scan updates, the shifted-in word is copied to `bnd_update`.
- R7: Under the external-test instruction (4'b0000), the boundary register takes part in data scans as under sample, and `pin_oe` equals `bnd_update[BLEN-1]`. Under every other instruction, `pin_oe` equals `func_oe`.
- R8: Reset and Test-Logic-Reset set `bnd_update` to 1 in its top (output-enable) bit and 0 in all other bits.
- R9: TDI and TMS are sampled on the rising edge of TCK, and TDO changes only on the falling edge. `tdo_en` is high only while the controller is in Shift-IR or Shift-DR. At other times TDO is 0.
- R10: Five consecutive rising edges with TMS high bring the controller to Test-Logic-Reset from any state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| rst | input | 1 | Synchronous active-high reset |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, updated on falling TCK |
| tdo_en | output | 1 | High while TDO carries scan data |
| bnd_capture | input | BLEN | Parallel values loaded into the boundary register on capture |
| bnd_update | output | BLEN | Boundary update register; top bit is the output-enable control |
| func_oe | input | 1 | Core's own pin output enable |
| pin_oe | output | 1 | Pin driver enable after test-mode selection |

## Verification
On every cycle, the checker confirms that a pass through Test-Logic-Reset leaves the identification instruction selected and the output-enable bit set. It confirms that an instruction capture leaves 1 as the first bit to shift out, that `tdo_en` tracks the two shift states, and that five TMS-high edges always end in Test-Logic-Reset. The value of the identification word, the one-stage delay of the bypass path, the decoding of unused codes, and the boundary capture and update values all depend on whole scan sequences. Only the bench's directed scans show these. The same holds for the rule that TDO stays still across a rising edge.

// File: rtl/tap_pkg.sv
package tap_pkg;

    localparam int IR_W = 4;

    localparam logic [IR_W-1:0] OP_EXTEST = 4'b0000;
    localparam logic [IR_W-1:0] OP_IDCODE = 4'b0001;
    localparam logic [IR_W-1:0] OP_SAMPLE = 4'b0010;
    localparam logic [IR_W-1:0] OP_BYPASS = 4'b1111;

    typedef enum logic [3:0] {
        ST_RESET, ST_IDLE,
        ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR, ST_UPD_DR,
        ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
    } tap_state_e;

    typedef enum logic [1:0] { PATH_BYP, PATH_ID, PATH_BND } dr_path_e;

    typedef struct packed {
        dr_path_e path;
        logic     extest;
        logic     bnd_load;
    } instr_dec_t;

    function automatic tap_state_e tap_next(input tap_state_e s, input logic m);
        unique case (s)
            ST_RESET:  return m ? ST_RESET  : ST_IDLE;
            ST_IDLE:   return m ? ST_SEL_DR : ST_IDLE;
            ST_SEL_DR: return m ? ST_SEL_IR : ST_CAP_DR;
            ST_CAP_DR: return m ? ST_EX1_DR : ST_SH_DR;
            ST_SH_DR:  return m ? ST_EX1_DR : ST_SH_DR;
            ST_EX1_DR: return m ? ST_UPD_DR : ST_PAU_DR;
            ST_PAU_DR: return m ? ST_EX2_DR : ST_PAU_DR;
            ST_EX2_DR: return m ? ST_UPD_DR : ST_SH_DR;
            ST_UPD_DR: return m ? ST_SEL_DR : ST_IDLE;
            ST_SEL_IR: return m ? ST_RESET  : ST_CAP_IR;
            ST_CAP_IR: return m ? ST_EX1_IR : ST_SH_IR;
            ST_SH_IR:  return m ? ST_EX1_IR : ST_SH_IR;
            ST_EX1_IR: return m ? ST_UPD_IR : ST_PAU_IR;
            ST_PAU_IR: return m ? ST_EX2_IR : ST_PAU_IR;
            ST_EX2_IR: return m ? ST_UPD_IR : ST_SH_IR;
            default:   return m ? ST_SEL_DR : ST_IDLE;
        endcase
    endfunction

    function automatic instr_dec_t decode(input logic [IR_W-1:0] op);
        instr_dec_t d;
        d = '{path: PATH_BYP, extest: 1'b0, bnd_load: 1'b0};
        unique case (op)
            OP_IDCODE: d.path = PATH_ID;
            OP_SAMPLE: begin d.path = PATH_BND; d.bnd_load = 1'b1; end
            OP_EXTEST: begin d.path = PATH_BND; d.bnd_load = 1'b1; d.extest = 1'b1; end
            default:   d.path = PATH_BYP;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/tap_fsm.sv
module tap_fsm
    import tap_pkg::*;
(
    input  logic       tck,
    input  logic       rst,
    input  logic       tms,
    output tap_state_e state
);
    always_ff @(posedge tck) begin
        if (rst) state <= ST_RESET;
        else     state <= tap_next(state, tms);
    end
endmodule

// File: rtl/tap_ir.sv
module tap_ir
    import tap_pkg::*;
(
    input  logic            tck,
    input  logic            rst,
    input  tap_state_e      state,
    input  logic            tdi,
    output logic [IR_W-1:0] ir_q,
    output logic            ir_tdo
);
    logic [IR_W-1:0] ir_sr;

    always_ff @(posedge tck) begin
        if (rst || state == ST_RESET) begin
            ir_q  <= OP_IDCODE;
            ir_sr <= '0;
        end else begin
            unique case (state)
                ST_CAP_IR: ir_sr <= IR_W'(2'b01);
                ST_SH_IR:  ir_sr <= {tdi, ir_sr[IR_W-1:1]};
                ST_UPD_IR: ir_q  <= ir_sr;
                default:   ir_sr <= ir_sr;
            endcase
        end
    end

    assign ir_tdo = ir_sr[0];
endmodule

// File: rtl/tap_dr.sv
module tap_dr
    import tap_pkg::*;
#(
    parameter int          BLEN    = 8,
    parameter logic [31:0] ID_WORD = 32'h1
) (
    input  logic            tck,
    input  logic            rst,
    input  tap_state_e      state,
    input  logic            tdi,
    input  instr_dec_t      dec,
    input  logic [BLEN-1:0] bnd_capture,
    output logic [BLEN-1:0] bnd_update,
    output logic            dr_tdo
);
    localparam logic [BLEN-1:0] UPD_PRESET = {1'b1, {(BLEN-1){1'b0}}};

    logic [31:0]     id_sr;
    logic            byp_q;
    logic [BLEN-1:0] bnd_sr;

    always_ff @(posedge tck) begin
        if (rst || state == ST_RESET) begin
            id_sr      <= '0;
            byp_q      <= 1'b0;
            bnd_sr     <= '0;
            bnd_update <= UPD_PRESET;
        end else begin
            unique case (state)
                ST_CAP_DR: begin
                    unique case (dec.path)
                        PATH_ID:  id_sr  <= ID_WORD;
                        PATH_BND: bnd_sr <= bnd_capture;
                        default:  byp_q  <= 1'b0;
                    endcase
                end
                ST_SH_DR: begin
                    unique case (dec.path)
                        PATH_ID:  id_sr  <= {tdi, id_sr[31:1]};
                        PATH_BND: bnd_sr <= {tdi, bnd_sr[BLEN-1:1]};
                        default:  byp_q  <= tdi;
                    endcase
                end
                ST_UPD_DR: if (dec.bnd_load) bnd_update <= bnd_sr;
                default: byp_q <= byp_q;
            endcase
        end
    end

    always_comb begin
        unique case (dec.path)
            PATH_ID:  dr_tdo = id_sr[0];
            PATH_BND: dr_tdo = bnd_sr[0];
            default:  dr_tdo = byp_q;
        endcase
    end
endmodule

// File: rtl/tap_port.sv
module tap_port
    import tap_pkg::*;
#(
    parameter int           BLEN     = 8,
    parameter logic [2:0]   ID_REV   = 3'b000,
    parameter logic [4:0]   ID_DEPTH = 5'b01011,
    parameter logic [5:0]   ID_ARCH  = 6'b100110,
    parameter logic [5:0]   ID_PART  = 6'b010010,
    parameter logic [10:0]  ID_MFR   = 11'h0A4
) (
    input  logic            tck,
    input  logic            rst,
    input  logic            tms,
    input  logic            tdi,
    output logic            tdo,
    output logic            tdo_en,
    input  logic [BLEN-1:0] bnd_capture,
    output logic [BLEN-1:0] bnd_update,
    input  logic            func_oe,
    output logic            pin_oe
);
    localparam logic [31:0] ID_WORD = {ID_REV, ID_DEPTH, ID_ARCH, ID_PART, ID_MFR, 1'b1};

    tap_state_e      state;
    logic [IR_W-1:0] ir_q;
    logic            ir_tdo;
    logic            dr_tdo;
    instr_dec_t      dec;

    tap_fsm u_fsm (.tck(tck), .rst(rst), .tms(tms), .state(state));

    tap_ir u_ir (
        .tck(tck), .rst(rst), .state(state), .tdi(tdi),
        .ir_q(ir_q), .ir_tdo(ir_tdo)
    );

    assign dec = decode(ir_q);

    tap_dr #(.BLEN(BLEN), .ID_WORD(ID_WORD)) u_dr (
        .tck(tck), .rst(rst), .state(state), .tdi(tdi), .dec(dec),
        .bnd_capture(bnd_capture), .bnd_update(bnd_update), .dr_tdo(dr_tdo)
    );

    always_ff @(negedge tck) begin
        if (rst) begin
            tdo    <= 1'b0;
            tdo_en <= 1'b0;
        end else begin
            tdo_en <= (state == ST_SH_IR) || (state == ST_SH_DR);
            tdo    <= (state == ST_SH_IR) ? ir_tdo :
                      (state == ST_SH_DR) ? dr_tdo : 1'b0;
        end
    end

    assign pin_oe = dec.extest ? bnd_update[BLEN-1] : func_oe;
endmodule

// File: rtl/tap_port_chk.sv
module tap_port_chk
    import tap_pkg::*;
#(
    parameter int BLEN = 8
) (
    input logic            tck,
    input logic            rst,
    input logic            tms,
    input logic            tdo_en,
    input tap_state_e      state,
    input logic [IR_W-1:0] ir_q,
    input logic            ir_lsb,
    input logic            oe_bit
);
    logic [2:0] tms_run;

    always_ff @(posedge tck) begin
        if (rst)           tms_run <= '0;
        else if (!tms)     tms_run <= '0;
        else if (tms_run != 3'd5) tms_run <= tms_run + 3'd1;
    end

    AST_CAPIR_LSB: assert property (@(posedge tck) disable iff (rst)
        state == ST_CAP_IR |=> ir_lsb == 1'b1); // R1

    AST_RESET_IDCODE: assert property (@(posedge tck) disable iff (rst)
        state == ST_RESET |=> ir_q == OP_IDCODE); // R2

    AST_OE_PRESET: assert property (@(posedge tck) disable iff (rst)
        state == ST_RESET |=> oe_bit == 1'b1); // R8

    AST_TDO_WINDOW: assert property (@(posedge tck) disable iff (rst)
        tdo_en == (state == ST_SH_IR || state == ST_SH_DR)); // R9

    AST_FIVE_TMS: assert property (@(posedge tck) disable iff (rst)
        tms_run == 3'd5 |-> state == ST_RESET); // R10
endmodule

bind tap_port tap_port_chk #(.BLEN(BLEN)) u_chk (
    .tck(tck), .rst(rst), .tms(tms), .tdo_en(tdo_en), .state(state),
    .ir_q(ir_q), .ir_lsb(ir_tdo), .oe_bit(bnd_update[BLEN-1])
);

// File: tb/tap_port_bench.sv
module tap_port_bench;
    localparam int BLEN = 8;
    localparam time CLK_PERIOD = 10ns;
    localparam logic [31:0] EXP_ID = {3'b000, 5'b01011, 6'b100110, 6'b010010, 11'h0A4, 1'b1};

    logic tck = 1'b0, rst = 1'b1, tms = 1'b1, tdi = 1'b0, func_oe = 1'b0;
    logic tdo, tdo_en, pin_oe;
    logic [BLEN-1:0] bnd_capture = '0;
    logic [BLEN-1:0] bnd_update;
    int n_chk = 0, n_fail = 0;

    tap_port #(.BLEN(BLEN)) u_tap_port (
        .tck(tck), .rst(rst), .tms(tms), .tdi(tdi), .tdo(tdo), .tdo_en(tdo_en),
        .bnd_capture(bnd_capture), .bnd_update(bnd_update),
        .func_oe(func_oe), .pin_oe(pin_oe)
    );

    always #(CLK_PERIOD/2) tck = ~tck;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic step(input logic m, input logic d, output logic o);
        @(negedge tck); #1;
        o = tdo; tms = m; tdi = d;
        @(posedge tck);
    endtask

    task automatic scan_ir(input logic [3:0] code, output logic [3:0] got);
        logic x;
        step(1, 0, x); step(1, 0, x); step(0, 0, x); step(0, 0, x);
        for (int i = 0; i < 4; i++) step(i == 3, code[i], got[i]);
        step(1, 0, x); step(0, 0, x);
    endtask

    task automatic scan_dr(input int n, input logic [31:0] din, output logic [31:0] got);
        logic x;
        got = '0;
        step(1, 0, x); step(0, 0, x); step(0, 0, x);
        for (int i = 0; i < n; i++) step(i == n - 1, din[i], got[i]);
        step(1, 0, x); step(0, 0, x);
    endtask

    task automatic t_reset;
        @(negedge tck); #1;
        chk("R8 preset after reset", 32'(bnd_update), 32'h80);
        chk("R9 tdo_en idle", 32'(tdo_en), 0);
        chk("R9 tdo idle", 32'(tdo), 0);
        chk("R7 pin_oe follows core", 32'(pin_oe), 32'(func_oe));
    endtask

    task automatic t_idcode;
        logic [31:0] got;
        logic x;
        step(0, 0, x);
        scan_dr(32, 32'h0, got);
        chk("R2 R3 idcode word", got, EXP_ID);
    endtask

    task automatic t_edge;
        logic x;
        step(1, 0, x); step(0, 0, x); step(0, 0, x);
        @(negedge tck); #1;
        chk("R9 tdo_en in shift", 32'(tdo_en), 1);
        chk("R3 bit0 first", 32'(tdo), 1);
        tms = 0; tdi = 0;
        @(posedge tck); #1;
        chk("R9 tdo held over rising edge", 32'(tdo), 1);
        @(negedge tck); #1;
        chk("R9 tdo moves on falling edge", 32'(tdo), 0);
        tms = 1;
        @(posedge tck);
        step(1, 0, x); step(0, 0, x);
    endtask

    task automatic t_ir_capture;
        logic [3:0] got;
        scan_ir(4'b1111, got);
        chk("R1 capture pattern", 32'(got), 32'h1);
    endtask

    task automatic t_bypass;
        logic [31:0] got;
        scan_dr(4, 32'hB, got);
        chk("R4 bypass delay", got, 32'h6);
    endtask

    task automatic t_unused;
        logic [3:0] g;
        logic [31:0] got;
        scan_ir(4'b0101, g);
        scan_dr(4, 32'hB, got);
        chk("R5 code 0101 acts as bypass", got, 32'h6);
        scan_ir(4'b1000, g);
        scan_dr(5, 32'h1D, got);
        chk("R5 code 1000 acts as bypass", got, 32'h1A);
    endtask

    task automatic t_sample;
        logic [3:0] g;
        logic [31:0] got;
        bnd_capture = 8'hA5; func_oe = 1;
        scan_ir(4'b0010, g);
        scan_dr(BLEN, 32'h3C, got);
        chk("R6 sample capture", got, 32'hA5);
        @(negedge tck); #1;
        chk("R6 sample update", 32'(bnd_update), 32'h3C);
        chk("R7 pin_oe from core under sample", 32'(pin_oe), 1);
    endtask

    task automatic t_extest;
        logic [3:0] g;
        logic [31:0] got;
        scan_ir(4'b0000, g);
        @(negedge tck); #1;
        chk("R7 extest oe bit low", 32'(pin_oe), 0);
        scan_dr(BLEN, 32'hC3, got);
        chk("R7 extest capture", got, 32'hA5);
        @(negedge tck); #1;
        chk("R7 extest update", 32'(bnd_update), 32'hC3);
        chk("R7 extest oe bit high", 32'(pin_oe), 1);
    endtask

    task automatic t_tms_reset;
        logic x;
        logic [31:0] got;
        step(1, 0, x); step(0, 0, x); step(0, 0, x);
        for (int i = 0; i < 5; i++) step(1, 0, x);
        step(0, 0, x);
        func_oe = 0;
        @(negedge tck); #1;
        chk("R8 preset after controller reset", 32'(bnd_update), 32'h80);
        chk("R2 extest released", 32'(pin_oe), 0);
        scan_dr(32, 32'h0, got);
        chk("R10 idcode after five TMS from Shift-DR", got, EXP_ID);
        step(1, 0, x); step(1, 0, x); step(0, 0, x); step(0, 0, x); step(0, 1, x);
        for (int i = 0; i < 5; i++) step(1, 0, x);
        step(0, 0, x);
        scan_dr(32, 32'h0, got);
        chk("R10 idcode after five TMS from Shift-IR", got, EXP_ID);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge tck);
        @(negedge tck); #1 rst = 0;
        t_reset;
        t_idcode;
        t_edge;
        t_ir_capture;
        t_bypass;
        t_unused;
        t_sample;
        t_extest;
        t_tms_reset;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule